// File: doc/BRIEF.md
# Two-Wire Character Display Slave Front End

This block is the serial slave side of a character display controller. It oversamples the two-wire clock and data lines with the system clock and recognises START and STOP. It matches a 7-bit device address and uses the direction bit to choose write mode or read mode.

In write mode, each control byte tells the block where the following bytes go: into the display data RAM or into a small instruction decoder. The decoder understands two instructions: set-address and return-home. An address counter points into the RAM.

Reads are served from a data register. That register is filled ahead of time, either by a set-address instruction or while the master acknowledges a byte. As a result, the first byte of a read returns whatever that register last held. This can be stale, for example after a return-home.

Top module: `dispctl_i2c_slave`

## Requirements
- R1: When the address byte after a START carries the device address in bits 7:1, the slave pulls SDA low in the following acknowledge slot. Bit 0 of that byte selects read mode (1) or write mode (0).
- R2: When the address does not match, the slave never drives SDA low until the next START, and the bytes of that transfer leave the RAM unchanged.
- R3: In write mode, bit 7 of a control byte is the continuation flag and bit 6 is the register select. With the flag at 1, every data byte is followed by a new control byte. With the flag at 0, all remaining bytes of the transfer are data bytes with the same select.
- R4: A data byte with select 1 is written to RAM at the address counter. The counter then advances by one, and it wraps from RAM_DEPTH-1 back to 0.
- R5: A data byte with select 0 of the form 1aaaaaaa is a set-address instruction. It loads the counter with a, or with 0 when a is not below RAM_DEPTH, and loads the data register with the RAM word at that address.
- R6: A data byte with select 0 of the form 0000001x is return-home. It clears the counter and changes neither the RAM nor the data register.
- R7: In read mode, the first byte sent is the data register content, most significant bit first. After reset the data register holds 0x00.
- R8: Each master acknowledge advances the counter by one, with the same wrap as R4. The next byte sent is the RAM word at the new counter value.
- R9: After a master not-acknowledge, or after a STOP, the slave releases SDA and stays silent until the next START.
- R10: During and after reset SDA is released. In write mode, every byte that follows a matching address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with its defaults: device address 0x3A, 80 RAM words and two synchroniser stages. With 80 words, a set-address to word 79 reaches the counter wrap in a single extra byte, both for writes and for prefetches. It also leaves the 7-bit address field able to carry values from 80 to 127, which exercises the clamp to zero. The serial half-period is twelve system clocks, well above the synchroniser delay, so START and STOP detection stays clear of the block's own data changes.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WBYTE,
    ST_SACK,
    ST_RBYTE,
    ST_MACK
  } dispctl_st_e;
endpackage

// File: rtl/dispctl_line_sync.sv
module dispctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/dispctl_ram.sv
module dispctl_ram #(
  parameter int DEPTH = 80,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;

  p_wr_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> int'(waddr_i) < DEPTH);
endmodule

// File: rtl/dispctl_i2c_slave.sv
module dispctl_i2c_slave
  import dispctl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
  parameter int         RAM_DEPTH   = 80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(RAM_DEPTH);

  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    dispctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_c, stop_c;
  assign scl_lvl  = lvl[0];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_lvl  = lvl[1];
  assign start_c  = scl_lvl & fall[1];
  assign stop_c   = scl_lvl & rise[1];

  function automatic logic [AW-1:0] ac_next(input logic [AW-1:0] a);
    return (int'(a) == RAM_DEPTH - 1) ? '0 : a + AW'(1);
  endfunction

  dispctl_st_e   state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sr_q, tx_q, dr_q;
  logic [AW-1:0] ac_q;
  logic          co_q, rs_q, want_ctrl_q, to_read_q, mack_ok_q, sda_oe_q;

  logic          byte_done, we, instr, is_home, is_set;
  logic [AW-1:0] set_target, raddr;
  logic [7:0]    rdata;

  assign byte_done  = scl_fall && !start_c && !stop_c && cnt_q == 4'd8 &&
                      (state_q == ST_ADDR || state_q == ST_WBYTE);
  assign we         = byte_done && state_q == ST_WBYTE && !want_ctrl_q && rs_q;
  assign instr      = byte_done && state_q == ST_WBYTE && !want_ctrl_q && !rs_q;
  assign is_home    = instr && sr_q[7:1] == 7'b0000001;
  assign is_set     = instr && sr_q[7];
  assign set_target = (int'(sr_q[6:0]) < RAM_DEPTH) ? AW'(sr_q[6:0]) : '0;
  assign raddr      = (state_q == ST_MACK) ? ac_next(ac_q) : set_target;

  dispctl_ram #(.DEPTH(RAM_DEPTH), .AW(AW), .DW(8)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(ac_q),
    .wdata_i(sr_q),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sr_q        <= '0;
      tx_q        <= '0;
      dr_q        <= '0;
      ac_q        <= '0;
      co_q        <= 1'b0;
      rs_q        <= 1'b0;
      want_ctrl_q <= 1'b1;
      to_read_q   <= 1'b0;
      mack_ok_q   <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else if (start_c) begin
      state_q     <= ST_ADDR;
      cnt_q       <= '0;
      want_ctrl_q <= 1'b1;
      sda_oe_q    <= 1'b0;
    end else if (stop_c) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sr_q  <= {sr_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_done) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (sr_q[7:1] == SLAVE_ADDR) begin
                sda_oe_q  <= 1'b1;
                state_q   <= ST_SACK;
                to_read_q <= sr_q[0];
                tx_q      <= dr_q;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              sda_oe_q  <= 1'b1;
              state_q   <= ST_SACK;
              to_read_q <= 1'b0;
              if (want_ctrl_q) begin
                co_q        <= sr_q[7];
                rs_q        <= sr_q[6];
                want_ctrl_q <= 1'b0;
              end else begin
                want_ctrl_q <= co_q;
                if (rs_q) ac_q <= ac_next(ac_q);
                else if (is_home) ac_q <= '0;
                else if (is_set) begin
                  ac_q <= set_target;
                  dr_q <= rdata;
                end
              end
            end
          end
        end
        ST_SACK: if (scl_fall) begin
          if (to_read_q) begin
            sda_oe_q <= ~tx_q[7];
            tx_q     <= {tx_q[6:0], 1'b0};
            cnt_q    <= 4'd1;
            state_q  <= ST_RBYTE;
          end else begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WBYTE;
          end
        end
        ST_RBYTE: if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            sda_oe_q  <= 1'b0;
            cnt_q     <= '0;
            mack_ok_q <= 1'b0;
            state_q   <= ST_MACK;
          end else begin
            sda_oe_q <= ~tx_q[7];
            tx_q     <= {tx_q[6:0], 1'b0};
            cnt_q    <= cnt_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_lvl) state_q <= ST_IDLE;
            else begin
              mack_ok_q <= 1'b1;
              ac_q      <= ac_next(ac_q);
              dr_q      <= rdata;
              tx_q      <= rdata;
            end
          end else if (scl_fall && mack_ok_q) begin
            sda_oe_q <= ~tx_q[7];
            tx_q     <= {tx_q[6:0], 1'b0};
            cnt_q    <= 4'd1;
            state_q  <= ST_RBYTE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  p_idle_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);
  p_mack_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MACK |-> !sda_oe_o);
  p_ac_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ac_q) < RAM_DEPTH);
  p_home_clears_ac_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_home |=> ac_q == '0);
  p_home_keeps_dr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_home |=> $stable(dr_q));
  p_mismatch_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_ADDR && sr_q[7:1] != SLAVE_ADDR) |=> !sda_oe_o);
endmodule

// File: tb/sim_dispctl_i2c_slave.sv
module sim_dispctl_i2c_slave;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int HP = 12;
  localparam logic [15:0] VEC [6] = '{16'h0048, 16'h0153, 16'h0521,
                                      16'h4F41, 16'h207E, 16'h33C3};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic mon_clr = 1'b0, mon_hit;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] rd_buf [4];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  dispctl_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  always @(posedge clk)
    if (mon_clr) mon_hit <= 1'b0;
    else if (sda_oe) mon_hit <= 1'b1;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tk(HP); scl_m = 1'b1; tk(HP);
    sda_m = 1'b0; tk(HP); scl_m = 1'b0; tk(HP);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tk(HP); scl_m = 1'b1; tk(HP); sda_m = 1'b1; tk(HP);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tk(HP); scl_m = 1'b1; tk(HP); scl_m = 1'b0;
    end
    sda_m = 1'b1; tk(HP); scl_m = 1'b1; tk(HP / 2);
    ack = !sda_line;
    tk(HP / 2); scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(HP); scl_m = 1'b1; tk(HP / 2); b[i] = sda_line; tk(HP / 2); scl_m = 1'b0;
    end
    sda_m = !mack; tk(HP); scl_m = 1'b1; tk(HP); scl_m = 1'b0; tk(2);
    sda_m = 1'b1;
  endtask

  task automatic w_ack(input logic [7:0] b, input string req);
    bit a;
    wbyte(b, a);
    chk(req, int'(a), 1);
  endtask

  task automatic instr(input logic [7:0] b);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack");
    w_ack(8'h00, "R10 ctrl ack"); w_ack(b, "R10 instr ack"); bstop();
  endtask

  task automatic set_addr(input logic [6:0] a);
    instr({1'b1, a});
  endtask

  task automatic wdata1(input logic [7:0] b);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack");
    w_ack(8'h40, "R10 ctrl ack"); w_ack(b, "R10 data ack"); bstop();
  endtask

  task automatic read_n(input int n);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack"); w_ack(8'h40, "R10 ctrl ack");
    bstart(); w_ack({DEV, 1'b1}, "R1 read addr ack");
    for (int k = 0; k < n; k++) rbyte(k < n - 1, rd_buf[k]);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] b;
    tk(3);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    tk(3); rst_n = 1'b1; tk(5);
    chk("R10 sda released after reset", int'(sda_oe), 0);
    read_n(2);
    chk("R7 data register reset value", rd_buf[0], 8'h00);
    chk("R8 prefetch after reset", rd_buf[1], 8'h00);

    // vector table: set-address then single write, then read back
    foreach (VEC[i]) begin
      set_addr(VEC[i][14:8]); wdata1(VEC[i][7:0]);
    end
    foreach (VEC[i]) begin
      set_addr(VEC[i][14:8]); read_n(1);
      chk("R5 R7 vector readback", rd_buf[0], VEC[i][7:0]);
    end

    // consecutive writes and sequential read
    set_addr(7'd10);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack"); w_ack(8'h40, "R10 ctrl ack");
    w_ack(8'h61, "R10"); w_ack(8'h62, "R10"); w_ack(8'h63, "R10"); bstop();
    set_addr(7'd10); read_n(3);
    chk("R4 seq write/read 0", rd_buf[0], 8'h61);
    chk("R8 seq read 1", rd_buf[1], 8'h62);
    chk("R8 seq read 2", rd_buf[2], 8'h63);

    // wrap at top of RAM
    set_addr(7'd79);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack"); w_ack(8'h40, "R10 ctrl ack");
    w_ack(8'h5A, "R10"); w_ack(8'h5B, "R10"); bstop();
    set_addr(7'd79); read_n(2);
    chk("R4 write at top", rd_buf[0], 8'h5A);
    chk("R8 prefetch wraps to 0 (R4 wrap write)", rd_buf[1], 8'h5B);

    // Co=1 alternating control bytes, then Co=0
    set_addr(7'd20);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack");
    w_ack(8'hC0, "R3"); w_ack(8'h11, "R3"); w_ack(8'h80, "R3"); w_ack(8'h02, "R3");
    w_ack(8'h40, "R3"); w_ack(8'h22, "R3"); w_ack(8'h33, "R3"); bstop();
    set_addr(7'd20); read_n(1);
    chk("R3 Co=1 data to RAM", rd_buf[0], 8'h11);
    set_addr(7'd0); read_n(2);
    chk("R3 Co=1 instr then data at home", rd_buf[0], 8'h22);
    chk("R3 Co=0 keeps data stream", rd_buf[1], 8'h33);

    // Co=0: instruction-like bytes are stored as data
    set_addr(7'd30);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack"); w_ack(8'h40, "R3");
    w_ack(8'h82, "R3"); w_ack(8'h02, "R3"); bstop();
    set_addr(7'd30); read_n(2);
    chk("R3 Co=0 byte 0x82 is data", rd_buf[0], 8'h82);
    chk("R3 Co=0 byte 0x02 is data", rd_buf[1], 8'h02);

    // stale data register after return-home
    set_addr(7'd5); instr(8'h02); read_n(2);
    chk("R6 R7 stale data register", rd_buf[0], 8'h21);
    chk("R6 home cleared counter", rd_buf[1], 8'h33);
    set_addr(7'd0); read_n(1);
    chk("R6 RAM unchanged by home", rd_buf[0], 8'h22);

    // set-address beyond depth clamps to 0
    set_addr(7'd80); read_n(1);
    chk("R5 out-of-range address clamps", rd_buf[0], 8'h22);

    // address mismatch
    set_addr(7'd2);
    mon_clr = 1'b1; tk(2); mon_clr = 1'b0;
    bstart(); wbyte({7'h3B, 1'b0}, a);
    chk("R2 mismatch write no ack", int'(a), 0);
    wbyte(8'h40, a); wbyte(8'h99, a); bstop();
    bstart(); wbyte({7'h3B, 1'b1}, a);
    chk("R2 mismatch read no ack", int'(a), 0);
    rbyte(1'b0, b); bstop();
    chk("R2 mismatch never drives", int'(mon_hit), 0);
    set_addr(7'd2); read_n(2);
    chk("R2 RAM untouched word 2", rd_buf[0], 8'h00);
    chk("R2 RAM untouched word 3", rd_buf[1], 8'h00);

    // master not-acknowledge releases the line
    set_addr(7'd10);
    bstart(); w_ack({DEV, 1'b0}, "R1 addr ack"); w_ack(8'h40, "R10 ctrl ack");
    bstart(); w_ack({DEV, 1'b1}, "R1 read addr ack");
    rbyte(1'b0, b);
    chk("R7 byte before nack", b, 8'h61);
    mon_clr = 1'b1; tk(2); mon_clr = 1'b0;
    rbyte(1'b0, b);
    chk("R9 line released after nack", b, 8'hFF);
    chk("R9 no drive after nack", int'(mon_hit), 0);
    bstop();

    finish_run();
  end
endmodule